// File: doc/BRIEF.md
# Stream Table Entry Locator

This block turns a stream ID into the memory address of that stream's 64-byte table entry. Two table layouts are supported. In the linear layout the entry sits at a fixed stride from the table base. In the two-level layout the stream ID is split at a programmable bit position. The upper part selects an 8-byte level-1 descriptor, which the block reads through its memory read port. The lower part is an offset into the level-2 table that the descriptor points to.

Each lookup ends with one result beat. The beat carries either the entry address or a fault code. A fault on the descriptor fetch also carries the address of that descriptor. The block serves one lookup at a time. Fetching and decoding the entry itself is left to the consumer of the result.

Top module: `stl_locator`

## Requirements
- R1: After reset, `busy`, `res_valid` and `mem_rd_valid` are all low.
- R2: A stream ID with any bit set at or above position SID_BITS (default 16) is refused in either layout. The result carries fault code 1 (bad stream), address 0, and no memory read is made.
- R3: The two-level layout is used only when the 2-bit `cfg_fmt` equals 1; the values 0, 2 and 3 select the linear layout. `cfg_fmt`, `cfg_split` and `cfg_base` are sampled when a request is accepted, and later changes do not affect that lookup.
- R4: In the linear layout the result is fault code 0 with address (cfg_base with bits [5:0] cleared) + stream ID × 64, truncated to ADDR_W bits, and no memory read is made.
- R5: In the two-level layout exactly one read is issued, as a single-cycle `mem_rd_valid`. Its address is (cfg_base with bits [5:0] cleared) + (stream ID >> cfg_split) × 8.
- R6: A response with `mem_rsp_err` high gives fault code 2 (fetch error), and `res_addr` is the descriptor address of R5.
- R7: A descriptor whose span field (bits [4:0]) is zero gives fault code 1 with address 0.
- R8: With a nonzero span, a level-2 offset (the stream ID masked to its low cfg_split bits) greater than 2^span − 1 gives fault code 3 (bad entry) with address 0. An offset equal to 2^span − 1 is accepted.
- R9: Otherwise the result is fault code 0 with address {descriptor bits [51:6], 6'b0} + offset × 64, truncated to ADDR_W bits.
- R10: `busy` rises in the cycle after a request is accepted and stays high up to and including the result cycle. `res_valid` is a single-cycle pulse. A request presented while `busy` is high is ignored.
- R11: For linear and out-of-range lookups, `res_valid` is high in the cycle right after acceptance. For two-level lookups, it is high in the cycle right after the response is taken. A response is taken in the cycle `mem_rd_valid` is high or in any later cycle before the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | ADDR_W | Table base address; bits [5:0] ignored |
| cfg_fmt | input | 2 | Layout select; 1 = two-level |
| cfg_split | input | 5 | Bit position splitting the stream ID |
| req_valid | input | 1 | Lookup request, taken when not busy |
| req_sid | input | SID_IN_W | Stream ID of the request |
| busy | output | 1 | A lookup is in progress |
| mem_rd_valid | output | 1 | Descriptor read request (one cycle) |
| mem_rd_addr | output | ADDR_W | Descriptor address |
| mem_rsp_valid | input | 1 | Descriptor read response |
| mem_rsp_err | input | 1 | Response carries a memory error |
| mem_rsp_data | input | 64 | Level-1 descriptor |
| res_valid | output | 1 | Result beat |
| res_ftype | output | 2 | 0 ok, 1 bad stream, 2 fetch error, 3 bad entry |
| res_addr | output | ADDR_W | Entry address, or descriptor address on fetch error |

## Verification
The assertions assume that the memory side answers only while a lookup is waiting for its descriptor: one response per read, and never in the result cycle. The bench keeps within this rule by driving `mem_rsp_valid` for exactly one cycle, 0 to 3 cycles after it sees the read. The assertions do not assume a quiet request line. The bench deliberately raises `req_valid` and disturbs the configuration in the middle of a lookup, to show that both are ignored until the block is idle again.

// File: rtl/stl_pkg.sv
// Shared types and fixed sizes for the stream table entry locator.
// Assumes level-1 descriptors of 8 bytes and table entries of 64 bytes.
package stl_pkg;
    localparam int DESC_BYTES_LOG2  = 3;
    localparam int ENTRY_BYTES_LOG2 = 6;
    localparam int DESC_W           = 64;
    localparam int SPAN_W           = 5;
    localparam int PTR_HI           = 51;
    localparam int PTR_LO           = 6;

    typedef enum logic [1:0] {
        FLT_NONE      = 2'd0,
        FLT_BAD_SID   = 2'd1,
        FLT_FETCH     = 2'd2,
        FLT_BAD_ENTRY = 2'd3
    } stl_fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } stl_state_e;
endpackage

// File: rtl/stl_sid_split.sv
// Splits a stream ID at a programmable bit into a level-1 index and a
// level-2 offset, and flags IDs outside the supported range.
// Assumes split values at or above SID_IN_W leave an index of zero.
module stl_sid_split #(
    parameter int SID_IN_W = 24,
    parameter int SID_BITS = 16,
    parameter int SPLIT_W  = 5
) (
    input  logic [SID_IN_W-1:0] sid,
    input  logic [SPLIT_W-1:0]  split,
    output logic [SID_IN_W-1:0] l1_idx,
    output logic [SID_IN_W-1:0] l2_off,
    output logic                out_of_range
);
    // Shift and mask the ID around the split position.
    always_comb begin
        l1_idx       = sid >> split;
        l2_off       = sid & ~({SID_IN_W{1'b1}} << split);
        out_of_range = (sid >> SID_BITS) != '0;
    end
endmodule

// File: rtl/stl_addr_gen.sv
// Forms the linear entry address and the level-1 descriptor address from
// the table base. Assumes ADDR_W is wide enough for the scaled stream ID.
module stl_addr_gen #(
    parameter int ADDR_W   = 48,
    parameter int SID_IN_W = 24
) (
    input  logic [ADDR_W-1:0]   base,
    input  logic [SID_IN_W-1:0] sid,
    input  logic [SID_IN_W-1:0] l1_idx,
    output logic [ADDR_W-1:0]   linear_addr,
    output logic [ADDR_W-1:0]   l1_addr
);
    import stl_pkg::*;
    localparam int PAD_W = ADDR_W - SID_IN_W;

    logic [ADDR_W-1:0] base_al;

    // Align the base and add the scaled index for each layout.
    always_comb begin
        base_al     = {base[ADDR_W-1:ENTRY_BYTES_LOG2], {ENTRY_BYTES_LOG2{1'b0}}};
        linear_addr = base_al + ({{PAD_W{1'b0}}, sid} << ENTRY_BYTES_LOG2);
        l1_addr     = base_al + ({{PAD_W{1'b0}}, l1_idx} << DESC_BYTES_LOG2);
    end
endmodule

// File: rtl/stl_desc_check.sv
// Checks a fetched level-1 descriptor against the level-2 offset and
// forms the entry address. Assumes span in bits [4:0], pointer in [51:6].
module stl_desc_check #(
    parameter int ADDR_W   = 48,
    parameter int SID_IN_W = 24
) (
    input  logic [stl_pkg::DESC_W-1:0] desc,
    input  logic [SID_IN_W-1:0]        l2_off,
    output stl_pkg::stl_fault_e        verdict,
    output logic [ADDR_W-1:0]          entry_addr
);
    import stl_pkg::*;
    localparam int PAD_W = ADDR_W - SID_IN_W;

    logic [SPAN_W-1:0] span;
    logic [ADDR_W-1:0] l2_ptr;

    // Pick the pointer slice that fits the address width.
    generate
        if (ADDR_W > PTR_HI + 1) begin : g_ptr_wide
            assign l2_ptr = {{(ADDR_W-PTR_HI-1){1'b0}}, desc[PTR_HI:PTR_LO], {PTR_LO{1'b0}}};
            logic unused_hi;
            assign unused_hi = ^{desc[DESC_W-1:PTR_HI+1], desc[PTR_LO-1:SPAN_W]};
        end else begin : g_ptr_narrow
            assign l2_ptr = {desc[ADDR_W-1:PTR_LO], {PTR_LO{1'b0}}};
            logic unused_hi;
            assign unused_hi = ^{desc[DESC_W-1:ADDR_W], desc[PTR_LO-1:SPAN_W]};
        end
    endgenerate

    // Judge span and offset, then add the scaled offset to the pointer.
    always_comb begin
        span       = desc[SPAN_W-1:0];
        entry_addr = l2_ptr + ({{PAD_W{1'b0}}, l2_off} << ENTRY_BYTES_LOG2);
        if (span == '0)
            verdict = FLT_BAD_SID;
        else if ((l2_off >> span) != '0)
            verdict = FLT_BAD_ENTRY;
        else
            verdict = FLT_NONE;
    end
endmodule

// File: rtl/stl_locator.sv
// Top of the stream table entry locator: accepts one lookup at a time,
// fetches the level-1 descriptor in two-level mode and returns one result.
// Assumes the memory side answers once per read and only while waiting.
module stl_locator #(
    parameter int ADDR_W   = 48,
    parameter int SID_IN_W = 24,
    parameter int SID_BITS = 16,
    parameter int SPLIT_W  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   cfg_base,
    input  logic [1:0]          cfg_fmt,
    input  logic [SPLIT_W-1:0]  cfg_split,
    input  logic                req_valid,
    input  logic [SID_IN_W-1:0] req_sid,
    output logic                busy,
    output logic                mem_rd_valid,
    output logic [ADDR_W-1:0]   mem_rd_addr,
    input  logic                mem_rsp_valid,
    input  logic                mem_rsp_err,
    input  logic [63:0]         mem_rsp_data,
    output logic                res_valid,
    output logic [1:0]          res_ftype,
    output logic [ADDR_W-1:0]   res_addr
);
    import stl_pkg::*;

    stl_state_e          state_q;
    logic [ADDR_W-1:0]   l1_addr_q;
    logic [SID_IN_W-1:0] off_q;
    stl_fault_e          ftype_q;
    logic [ADDR_W-1:0]   raddr_q;

    logic [SID_IN_W-1:0] l1_idx, l2_off;
    logic                sid_oor;
    logic [ADDR_W-1:0]   linear_addr, l1_addr, entry_addr;
    stl_fault_e          verdict;

    stl_sid_split #(.SID_IN_W(SID_IN_W), .SID_BITS(SID_BITS), .SPLIT_W(SPLIT_W)) split_i (
        .sid(req_sid), .split(cfg_split),
        .l1_idx(l1_idx), .l2_off(l2_off), .out_of_range(sid_oor)
    );

    stl_addr_gen #(.ADDR_W(ADDR_W), .SID_IN_W(SID_IN_W)) addr_i (
        .base(cfg_base), .sid(req_sid), .l1_idx(l1_idx),
        .linear_addr(linear_addr), .l1_addr(l1_addr)
    );

    stl_desc_check #(.ADDR_W(ADDR_W), .SID_IN_W(SID_IN_W)) desc_i (
        .desc(mem_rsp_data), .l2_off(off_q),
        .verdict(verdict), .entry_addr(entry_addr)
    );

    // Lookup sequencer: accept, fetch, wait for response, present result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            l1_addr_q <= '0;
            off_q     <= '0;
            ftype_q   <= FLT_NONE;
            raddr_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (sid_oor) begin
                            ftype_q <= FLT_BAD_SID;
                            raddr_q <= '0;
                            state_q <= ST_DONE;
                        end else if (cfg_fmt == 2'd1) begin
                            l1_addr_q <= l1_addr;
                            off_q     <= l2_off;
                            state_q   <= ST_FETCH;
                        end else begin
                            ftype_q <= FLT_NONE;
                            raddr_q <= linear_addr;
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_FETCH, ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        state_q <= ST_DONE;
                        if (mem_rsp_err) begin
                            ftype_q <= FLT_FETCH;
                            raddr_q <= l1_addr_q;
                        end else begin
                            ftype_q <= verdict;
                            raddr_q <= (verdict == FLT_NONE) ? entry_addr : '0;
                        end
                    end else begin
                        state_q <= ST_WAIT;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the port-side views of the sequencer state.
    always_comb begin
        busy         = (state_q != ST_IDLE);
        mem_rd_valid = (state_q == ST_FETCH);
        mem_rd_addr  = l1_addr_q;
        res_valid    = (state_q == ST_DONE);
        res_ftype    = ftype_q;
        res_addr     = raddr_q;
    end
endmodule

// File: rtl/stl_locator_chk.sv
// Protocol checker for the stream table entry locator, bound to the top.
// Assumes responses arrive only while a lookup waits for its descriptor.
module stl_locator_chk #(
    parameter int ADDR_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              mem_rd_valid,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rsp_valid,
    input logic              res_valid,
    input logic [1:0]        res_ftype,
    input logic [ADDR_W-1:0] res_addr
);
    p_rd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |=> !mem_rd_valid);

    p_rd_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> (mem_rd_addr[2:0] == 3'd0));

    p_rd_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> busy);

    p_res_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_res_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> busy);

    p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    p_busy_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(res_valid));

    p_entry_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ftype == 2'd0) |-> (res_addr[5:0] == 6'd0));

    p_fault_zero_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_ftype == 2'd1 || res_ftype == 2'd3)) |-> (res_addr == '0));

    p_rsp_in_lookup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> (busy && !res_valid));
endmodule

bind stl_locator stl_locator_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .res_valid(res_valid),
    .res_ftype(res_ftype), .res_addr(res_addr)
);

// File: tb/stl_locator_tb_top.sv
// Bench for the stream table entry locator: seeded random lookups plus
// directed corners, each compared with a bench-side reference model.
module stl_locator_tb_top;
    localparam int ADDR_W   = 48;
    localparam int SID_IN_W = 24;
    localparam int SID_BITS = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [1:0]        cfg_fmt = '0;
    logic [4:0]        cfg_split = '0;
    logic              req_valid = 1'b0;
    logic [SID_IN_W-1:0] req_sid = '0;
    logic              busy, mem_rd_valid, res_valid;
    logic [ADDR_W-1:0] mem_rd_addr, res_addr;
    logic              mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
    logic [63:0]       mem_rsp_data = '0;
    logic [1:0]        res_ftype;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    stl_locator #(.ADDR_W(ADDR_W), .SID_IN_W(SID_IN_W), .SID_BITS(SID_BITS)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_fmt(cfg_fmt),
        .cfg_split(cfg_split), .req_valid(req_valid), .req_sid(req_sid),
        .busy(busy), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
        .mem_rsp_data(mem_rsp_data), .res_valid(res_valid),
        .res_ftype(res_ftype), .res_addr(res_addr)
    );

    // Watchdog: a hung run counts as a miscompare and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec = n_vec + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Reference model of one lookup, written from the requirements.
    task automatic model(input logic [23:0] sid, input logic [1:0] fmt, input logic [4:0] split,
                         input logic [47:0] base, input logic [63:0] desc, input bit err,
                         output logic [1:0] ft, output logic [63:0] addr,
                         output bit reads, output logic [63:0] l1a);
        logic [63:0] amask, b, off, ptr, maxo;
        amask = (64'd1 << ADDR_W) - 64'd1;
        b     = {16'd0, base} & ~64'd63;
        l1a   = (b + ((64'(sid) >> split) << 3)) & amask;
        off   = 64'(sid) & ((64'd1 << split) - 64'd1);
        ptr   = desc & 64'h000F_FFFF_FFFF_FFC0;
        reads = 1'b0;
        if (64'(sid) >= (64'd1 << SID_BITS)) begin
            ft = 2'd1; addr = 64'd0;                      // R2
        end else if (fmt != 2'd1) begin
            ft = 2'd0; addr = (b + (64'(sid) << 6)) & amask; // R4
        end else begin
            reads = 1'b1;
            maxo  = (64'd1 << desc[4:0]) - 64'd1;
            if (err)                 begin ft = 2'd2; addr = l1a; end   // R6
            else if (desc[4:0] == 0) begin ft = 2'd1; addr = 64'd0; end // R7
            else if (off > maxo)     begin ft = 2'd3; addr = 64'd0; end // R8
            else begin ft = 2'd0; addr = (ptr + (off << 6)) & amask; end // R9
        end
    endtask

    // Run one lookup with a response delay; optionally disturb inputs mid-way.
    task automatic lookup(input logic [23:0] sid, input logic [1:0] fmt, input logic [4:0] split,
                          input logic [47:0] base, input logic [63:0] desc, input bit err,
                          input int dly, input bit intrude);
        logic [1:0]  eft;
        logic [63:0] eaddr, el1;
        bit          ereads, got;
        int          nreads, pend, rdc;
        model(sid, fmt, split, base, desc, err, eft, eaddr, ereads, el1);
        cfg_fmt = fmt; cfg_split = split; cfg_base = base;
        req_sid = sid; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 busy after accept", 64'(busy), 64'd1);
        got = 1'b0; nreads = 0; pend = -1; rdc = -1;
        for (int c = 0; c < 40 && !got; c++) begin
            mem_rsp_valid = 1'b0;
            if (intrude && c == 1) begin
                req_valid = 1'b1; req_sid = ~sid;
                cfg_base = ~base; cfg_split = split + 5'd3; cfg_fmt = fmt ^ 2'd1;
            end else if (intrude && c == 2) begin
                req_valid = 1'b0;
                cfg_base = base; cfg_split = split; cfg_fmt = fmt;
            end
            if (mem_rd_valid) begin
                nreads++;
                rdc = c;
                check("R5 descriptor address", 64'(mem_rd_addr), el1);
                pend = dly;
            end
            if (pend == 0) begin
                mem_rsp_valid = 1'b1; mem_rsp_err = err; mem_rsp_data = desc;
                pend = -1;
            end else if (pend > 0) begin
                pend--;
            end
            if (res_valid) begin
                got = 1'b1;
                check("R2/R6/R7/R8 fault code", 64'(res_ftype), 64'(eft));
                check("R4/R6/R9 result address", 64'(res_addr), eaddr);
                check("R11 result cycle", 64'(c), ereads ? 64'(rdc + dly + 1) : 64'd0);
            end
            @(negedge clk);
        end
        mem_rsp_valid = 1'b0;
        req_valid = 1'b0;
        check("R10 result seen once", 64'(got), 64'd1);
        check("R2/R4/R5 read count", 64'(nreads), 64'(ereads));
        check("R10 idle after result", 64'({busy, res_valid}), 64'd0);
    endtask

    initial begin
        logic [63:0] d;
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", 64'({busy, res_valid, mem_rd_valid}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 64'({busy, res_valid, mem_rd_valid}), 64'd0);

        // R4: linear layout for each non-two-level format value (R3)
        lookup(24'h00_1234, 2'd0, 5'd4, 48'h1234_5678_9A7F, 64'd0, 1'b0, 0, 1'b0);
        lookup(24'h00_FFFF, 2'd2, 5'd4, 48'hFFFF_FFFF_FFC0, 64'd0, 1'b0, 0, 1'b0);
        lookup(24'h00_0001, 2'd3, 5'd9, 48'h0000_0000_1000, 64'd0, 1'b0, 0, 1'b0);
        // R2: range edge, both layouts
        lookup(24'h01_0000, 2'd0, 5'd4, 48'h1000, 64'd0, 1'b0, 0, 1'b0);
        lookup(24'h01_0000, 2'd1, 5'd4, 48'h1000, 64'd0, 1'b0, 0, 1'b0);
        lookup(24'h80_0003, 2'd1, 5'd4, 48'h1000, 64'd0, 1'b0, 0, 1'b0);
        lookup(24'h00_FFFF, 2'd1, 5'd8, 48'h2000, 64'h0000_0000_ABCD_0008, 1'b0, 0, 1'b0);
        // R6: fetch error returns descriptor address
        lookup(24'h00_0456, 2'd1, 5'd6, 48'h3000_0040, 64'h5, 1'b1, 2, 1'b0);
        // R7: zero span
        lookup(24'h00_0020, 2'd1, 5'd4, 48'h4000, 64'h0000_0000_0001_0000, 1'b0, 1, 1'b0);
        // R8: offset at max accepted, max+1 refused
        lookup(24'h00_0107, 2'd1, 5'd4, 48'h5000, 64'h000F_FFFF_FFFF_FFC3, 1'b0, 0, 1'b0);
        lookup(24'h00_0108, 2'd1, 5'd4, 48'h5000, 64'h0000_0000_0040_0003, 1'b0, 3, 1'b0);
        // R9: split 0 (offset 0) and split beyond ID width (index 0)
        lookup(24'h00_0ABC, 2'd1, 5'd0, 48'h6000, 64'h0000_1234_5678_0001, 1'b0, 0, 1'b0);
        lookup(24'h00_0ABC, 2'd1, 5'd31, 48'h7000, 64'h0000_0000_8000_0010, 1'b0, 1, 1'b0);
        // R3/R10: request and configuration disturbed while busy
        lookup(24'h00_0333, 2'd1, 5'd5, 48'h8000, 64'h0000_0000_0C00_0005, 1'b0, 3, 1'b1);
        lookup(24'h00_0777, 2'd1, 5'd7, 48'h9000, 64'h0, 1'b1, 2, 1'b1);

        // Constrained random mix of layouts, splits, spans and errors
        for (int i = 0; i < 400; i++) begin
            logic [23:0] sid;
            logic [1:0]  fmt;
            logic [4:0]  split, span;
            int          dly;
            sid   = ($urandom_range(0, 9) == 0) ? 24'($urandom) : 24'($urandom_range(0, 65535));
            fmt   = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'd1;
            split = 5'($urandom_range(0, 20));
            span  = ($urandom_range(0, 7) == 0) ? 5'd0 : 5'($urandom_range(1, 20));
            d     = {$urandom, $urandom};
            d[4:0] = span;
            dly   = $urandom_range(0, 3);
            lookup(sid, fmt, split, {$urandom, $urandom}, d, ($urandom_range(0, 7) == 0),
                   dly, (dly >= 2) && ($urandom_range(0, 3) == 0));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule